// File: doc/BRIEF.md
# Loop Replay Micro-op Buffer

This block sits between the decoders and the rename/issue stage. It queues decoded micro-ops, and micro-ops from microcode take the same path. While it streams, it watches the accepted micro-ops for a tight loop: a taken branch whose target tag matches one of the micro-ops still held in the ring. When the same branch has closed the same loop a set number of times in a row, the block locks onto the loop. From then on it stops accepting input and raises a gate that lets fetch and decode go idle. It then replays the captured body from its own storage every cycle, with no wait on the front end.

Each micro-op carries a tag naming its position in the program, and a taken branch carries the tag of the micro-op it jumps to. Both streams are valid/ready. A word moves on a side only in a cycle where valid and ready are both high. The upstream side sees ready low when the ring holds its full count of unread entries and also during replay. The downstream side may hold ready low for any number of cycles, and the head word then stays put. Replay ends when the back end reports that the loop branch fell through, or when a flush arrives. Either one drops the gate at once and empties the ring.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset, out_valid and fetch_idle are 0 and in_ready is 1.
- R2: In stream mode, micro-ops leave in acceptance order. A micro-op accepted at one clock edge is presented at the output from the next cycle on, and out_valid is high whenever unread entries exist.
- R3: in_ready is low whenever DEPTH (28) unread entries are held. While out_valid is high and out_ready is low, the output word is unchanged in the next cycle unless a kill arrives.
- R4: An accepted micro-op with in_is_br=1 and in_br_taken=1 counts as one loop iteration only if its in_br_tgt equals the tag of one of the DEPTH-1 most recently accepted micro-ops since the last reset or kill. When the tag occurs several times, the most recent occurrence is taken as the loop start.
- R5: The block locks when the same branch, with the same branch tag and the same target tag, completes LOCK_ITERS (default 2) iterations in a row. From the cycle after the locking branch is accepted, fetch_idle is 1 and in_ready is 0.
- R6: During replay, out_valid stays 1. The output first delivers any entries that were unread at lock, ending with the locking branch. It then repeats the loop body, from the start micro-op through the branch, for as long as replay lasts.
- R7: If the candidate branch tag is accepted as not taken, or taken with no match, the iteration count is cleared. A matching taken branch of a different loop restarts the count at 1.
- R8: In any cycle where flush or loop_exit is 1, out_valid, in_ready and fetch_idle are 0 in that same cycle. From the next cycle the ring is empty and stream mode resumes.
- R9: A loop body of DEPTH micro-ops, counting the target and the branch, can lock. A body of DEPTH+1 cannot.
- R10: A kill also clears the match history and the iteration count, so iterations seen before it do not count toward a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded micro-op offered |
| in_ready | output | 1 | Block accepts the offered micro-op |
| in_uop | input | UOP_W | Micro-op payload |
| in_tag | input | TAG_W | Program-position tag of the micro-op |
| in_is_br | input | 1 | Micro-op is a branch |
| in_br_taken | input | 1 | Branch was predicted taken |
| in_br_tgt | input | TAG_W | Tag of the branch target micro-op |
| out_valid | output | 1 | Micro-op presented to rename/issue |
| out_ready | input | 1 | Rename/issue takes the presented micro-op |
| out_uop | output | UOP_W | Presented micro-op payload |
| out_tag | output | TAG_W | Presented micro-op tag |
| fetch_idle | output | 1 | Fetch and decode may shut down (replay active) |
| flush | input | 1 | Pipeline flush, empties the block |
| loop_exit | input | 1 | Back end resolved the loop branch as falling through |

## Verification
An accepted micro-op becomes visible at the output in the cycle after its acceptance edge. The gate rises in the cycle after the locking branch is accepted. A kill acts on valid, ready and the gate in its own cycle and empties the ring by the next cycle. The bench drives inputs on the falling edge and samples all outputs 1 ns later. At each rising edge it then advances a model built from these rules: a queue of unread words, the recent tag history, the candidate loop and the replay body. Every cycle's outputs are therefore compared with what that cycle is due to show.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  typedef enum logic {
    LRB_STREAM = 1'b0,
    LRB_REPLAY = 1'b1
  } lrb_mode_e;

  // ring index that lies d places behind base in a ring of depth entries
  function automatic int ring_back(input int base, input int d, input int depth);
    return (base >= d) ? (base - d) : (base + depth - d);
  endfunction

endpackage

// File: rtl/lrb_ring.sv
module lrb_ring #(
  parameter int DEPTH = 28,
  parameter int UOP_W = 32,
  parameter int TAG_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [UOP_W-1:0] wr_uop,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [UOP_W-1:0] rd_uop,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [TAG_W-1:0] srch_tag,
  input  logic [PTR_W-1:0] srch_base,
  output logic             hit,
  output logic [PTR_W-1:0] hit_idx
);

  logic [UOP_W-1:0] uop_mem [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] held;
  logic [DEPTH-1:0] tag_eq;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      uop_mem[wr_idx] <= wr_uop;
      tag_mem[wr_idx] <= wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (clr)   held <= '0;
    else if (wr_en) held[wr_idx] <= 1'b1;
  end

  assign rd_uop = uop_mem[rd_idx];
  assign rd_tag = tag_mem[rd_idx];

  // per-entry compare; the slot about to be overwritten is outside the window
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign tag_eq[i] = held[i] && (tag_mem[i] == srch_tag) && (PTR_W'(i) != srch_base);
  end

  // walk from oldest to newest so the nearest match wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int d = DEPTH - 1; d >= 1; d--) begin
      if (tag_eq[lrb_pkg::ring_back(int'(srch_base), d, DEPTH)]) begin
        hit     = 1'b1;
        hit_idx = PTR_W'(lrb_pkg::ring_back(int'(srch_base), d, DEPTH));
      end
    end
  end

  // R4: a reported match always points at a slot that holds a live entry
  p_hit_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (held[hit_idx] && hit_idx != srch_base));

endmodule

// File: rtl/lrb_lock.sv
module lrb_lock #(
  parameter int TAG_W      = 8,
  parameter int LOCK_ITERS = 2,
  localparam int CNT_W = $clog2(LOCK_ITERS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  input  logic             is_br,
  input  logic             taken,
  input  logic             hit,
  input  logic [TAG_W-1:0] br_tag,
  input  logic [TAG_W-1:0] tgt_tag,
  output logic             lock_now
);

  logic             cand_vld;
  logic [TAG_W-1:0] cand_br;
  logic [TAG_W-1:0] cand_tgt;
  logic [CNT_W-1:0] cnt;
  logic             same;
  logic             iter;
  logic [CNT_W:0]   next_cnt;

  assign same     = cand_vld && (cand_br == br_tag) && (cand_tgt == tgt_tag);
  assign iter     = acc && is_br && taken && hit;
  assign next_cnt = same ? ({1'b0, cnt} + 1'b1) : (CNT_W + 1)'(1);
  assign lock_now = iter && (next_cnt >= (CNT_W + 1)'(LOCK_ITERS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_vld <= 1'b0;
      cand_br  <= '0;
      cand_tgt <= '0;
      cnt      <= '0;
    end else if (clr || lock_now) begin
      cand_vld <= 1'b0;
      cnt      <= '0;
    end else if (iter) begin
      cand_vld <= 1'b1;
      cand_br  <= br_tag;
      cand_tgt <= tgt_tag;
      cnt      <= next_cnt[CNT_W-1:0];
    end else if (acc && is_br && cand_vld && (br_tag == cand_br)) begin
      cand_vld <= 1'b0;
      cnt      <= '0;
    end
  end

  // R5: the stored count never reaches the lock threshold
  p_cnt_below_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LOCK_ITERS));

  // R7: a fall-through of the candidate branch leaves no iteration pending
  p_fallthru_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_br && !taken && cand_vld && br_tag == cand_br) |=> (cnt == '0));

endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf #(
  parameter int DEPTH      = 28,
  parameter int UOP_W      = 32,
  parameter int TAG_W      = 8,
  parameter int LOCK_ITERS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [UOP_W-1:0] in_uop,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_is_br,
  input  logic             in_br_taken,
  input  logic [TAG_W-1:0] in_br_tgt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [UOP_W-1:0] out_uop,
  output logic [TAG_W-1:0] out_tag,
  output logic             fetch_idle,
  input  logic             flush,
  input  logic             loop_exit
);
  import lrb_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lrb_mode_e        mode_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, loop_start, loop_end;
  logic [CNT_W-1:0] count;
  logic             kill, replay, acc, pop, lock_now, hit;
  logic [PTR_W-1:0] hit_idx;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign kill       = flush || loop_exit;
  assign replay     = (mode_q == LRB_REPLAY);
  assign in_ready   = !kill && !replay && (count != CNT_W'(DEPTH));
  assign out_valid  = !kill && (replay || count != '0);
  assign fetch_idle = replay && !kill;
  assign acc        = in_valid && in_ready;
  assign pop        = out_valid && out_ready;

  lrb_ring #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (kill),
    .wr_en    (acc),
    .wr_idx   (wr_ptr),
    .wr_uop   (in_uop),
    .wr_tag   (in_tag),
    .rd_idx   (rd_ptr),
    .rd_uop   (out_uop),
    .rd_tag   (out_tag),
    .srch_tag (in_br_tgt),
    .srch_base(wr_ptr),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  lrb_lock #(.TAG_W(TAG_W), .LOCK_ITERS(LOCK_ITERS)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (kill),
    .acc     (acc),
    .is_br   (in_is_br),
    .taken   (in_br_taken),
    .hit     (hit),
    .br_tag  (in_tag),
    .tgt_tag (in_br_tgt),
    .lock_now(lock_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= LRB_STREAM;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      loop_start <= '0;
      loop_end   <= '0;
    end else if (kill) begin
      mode_q     <= LRB_STREAM;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      loop_start <= '0;
      loop_end   <= '0;
    end else begin
      if (acc) wr_ptr <= ptr_inc(wr_ptr);
      if (pop) rd_ptr <= (replay && rd_ptr == loop_end) ? loop_start : ptr_inc(rd_ptr);
      if (replay) begin
        if (pop && count != '0) count <= count - 1'b1;
      end else begin
        case ({acc, pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
      if (lock_now) begin
        mode_q     <= LRB_REPLAY;
        loop_start <= hit_idx;
        loop_end   <= wr_ptr;
      end
    end
  end

  // R3: occupancy never exceeds the ring
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: a stalled head word holds until taken or killed
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (flush || loop_exit || (out_valid && $stable(out_uop) && $stable(out_tag))));

  // R5: the gate follows the locking branch by one cycle and blocks input
  p_lock_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_now |=> (fetch_idle || flush || loop_exit));
  p_idle_blocks_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_idle |-> !in_ready);

  // R8: a kill leaves the block empty and ungated in the following cycle
  p_kill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || loop_exit) |=> (!fetch_idle && !out_valid));

  // R9: a locked body spans at least two slots and fits in the ring
  p_body_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> (loop_start != loop_end));

endmodule

// File: tb/loop_replay_buf_tb.sv
module loop_replay_buf_tb;
  localparam int DEPTH = 28;
  localparam int UOP_W = 32;
  localparam int TAG_W = 8;
  localparam int LOCK_ITERS = 2;
  localparam int EW = UOP_W + TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_br = 1'b0, in_br_taken = 1'b0;
  logic [UOP_W-1:0] in_uop = '0;
  logic [TAG_W-1:0] in_tag = '0, in_br_tgt = '0;
  logic out_ready = 1'b0, flush = 1'b0, loop_exit = 1'b0;
  logic in_ready, out_valid, fetch_idle;
  logic [UOP_W-1:0] out_uop;
  logic [TAG_W-1:0] out_tag;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  loop_replay_buf #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W), .LOCK_ITERS(LOCK_ITERS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_uop(in_uop),
    .in_tag(in_tag), .in_is_br(in_is_br), .in_br_taken(in_br_taken), .in_br_tgt(in_br_tgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_uop(out_uop), .out_tag(out_tag),
    .fetch_idle(fetch_idle), .flush(flush), .loop_exit(loop_exit)
  );

  // reference state derived from the requirements
  logic [EW-1:0] pend[$];
  logic [EW-1:0] hist[$];
  logic [EW-1:0] body[$];
  int  bpos = 0;
  bit  m_rep = 0;
  bit  c_vld = 0;
  logic [TAG_W-1:0] c_br = '0, c_tgt = '0;
  int  c_cnt = 0;
  bit  last_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    pend.delete(); hist.delete(); body.delete();
    bpos = 0; m_rep = 0; c_vld = 0; c_cnt = 0;
  endtask

  task automatic step();
    bit kill, e_ir, e_ov, e_fi, pop;
    logic [EW-1:0] head, ent;
    int j;
    #1;
    kill = flush || loop_exit;
    e_ir = !kill && !m_rep && (pend.size() < DEPTH);
    e_ov = !kill && (m_rep || pend.size() > 0);
    e_fi = m_rep && !kill;
    head = (pend.size() > 0) ? pend[0] : ((body.size() > 0) ? body[bpos] : '0);
    chk(in_ready == e_ir, kill ? "R8" : (m_rep ? "R5" : "R3"), "in_ready", 64'(in_ready), 64'(e_ir));
    chk(out_valid == e_ov, kill ? "R8" : (m_rep ? "R6" : "R2"), "out_valid", 64'(out_valid), 64'(e_ov));
    chk(fetch_idle == e_fi, kill ? "R8" : "R5", "fetch_idle", 64'(fetch_idle), 64'(e_fi));
    if (e_ov)
      chk({out_uop, out_tag} == head, m_rep ? "R6" : "R2", "out word", 64'({out_uop, out_tag}), 64'(head));
    last_acc = in_valid && e_ir;
    pop = e_ov && out_ready;
    if (kill) model_clear();
    else begin
      if (pop) begin
        if (pend.size() > 0) void'(pend.pop_front());
        else bpos = (bpos + 1) % body.size();
      end
      if (last_acc) begin
        ent = {in_uop, in_tag};
        j = -1;
        for (int k = hist.size() - 1; k >= 0; k--)
          if (j < 0 && hist[k][TAG_W-1:0] == in_br_tgt) j = k;
        if (in_is_br && in_br_taken && j >= 0) begin
          if (c_vld && c_br == in_tag && c_tgt == in_br_tgt) c_cnt++;
          else begin c_vld = 1; c_br = in_tag; c_tgt = in_br_tgt; c_cnt = 1; end
          if (c_cnt >= LOCK_ITERS) begin
            m_rep = 1; c_vld = 0; c_cnt = 0;
            body.delete(); bpos = 0;
            for (int k = j; k < hist.size(); k++) body.push_back(hist[k]);
            body.push_back(ent);
          end
        end else if (in_is_br && c_vld && in_tag == c_br) begin
          c_vld = 0; c_cnt = 0;
        end
        pend.push_back(ent);
        hist.push_back(ent);
        if (hist.size() > DEPTH - 1) void'(hist.pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic send(input int tag, input bit isb, input bit tk, input int tgt);
    in_valid = 1; in_tag = TAG_W'(tag); in_is_br = isb; in_br_taken = tk;
    in_br_tgt = TAG_W'(tgt); in_uop = $urandom;
    do step(); while (!last_acc);
    in_valid = 0; in_is_br = 0; in_br_taken = 0;
  endtask

  // one pass of a loop: tags first..last-1 plain, last is the branch back to first
  task automatic loop_pass(input int first, input int last, input bit tk);
    for (int t = first; t < last; t++) send(t, 0, 0, 0);
    send(last, 1, tk, first);
  endtask

  task automatic do_flush();
    flush = 1; step(); flush = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int acc_n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    chk(out_valid == 0 && fetch_idle == 0, "R1", "valid/gate after reset", 64'({out_valid, fetch_idle}), 64'(0));
    chk(in_ready == 1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));
    @(negedge clk);

    // R3: fill with no drain, then drain in order (R2)
    acc_n = 0;
    in_valid = 1;
    for (int i = 0; i < DEPTH + 4; i++) begin
      in_tag = TAG_W'(200 + i); in_uop = $urandom;
      step();
      if (last_acc) acc_n++;
    end
    in_valid = 0;
    chk(acc_n == DEPTH, "R3", "accepted before full", 64'(acc_n), 64'(DEPTH));
    chk(in_ready == 0, "R3", "ready low when full", 64'(in_ready), 64'(0));
    for (int i = 0; i < DEPTH + 4; i++) begin out_ready = ($urandom % 3) != 0; step(); end
    out_ready = 1;
    repeat (DEPTH) step();
    chk(out_valid == 0, "R2", "drained", 64'(out_valid), 64'(0));

    // R5/R6: a five-op loop locks after two passes, then replays; R8 via loop_exit
    out_ready = 1;
    loop_pass(10, 14, 1);
    chk(fetch_idle == 0, "R5", "no gate after one pass", 64'(fetch_idle), 64'(0));
    loop_pass(10, 14, 1);
    chk(fetch_idle == 1, "R5", "gate after second pass", 64'(fetch_idle), 64'(1));
    for (int i = 0; i < 120; i++) begin out_ready = ($urandom % 4) != 0; step(); end
    loop_exit = 1; step(); loop_exit = 0;
    #1;
    chk(out_valid == 0 && fetch_idle == 0, "R8", "empty after exit", 64'({out_valid, fetch_idle}), 64'(0));
    chk(in_ready == 1, "R8", "stream resumes", 64'(in_ready), 64'(1));
    @(negedge clk);

    // R7: fall-through resets the count
    out_ready = 1;
    loop_pass(20, 23, 1);
    send(23, 1, 0, 20);
    loop_pass(20, 23, 1);
    chk(fetch_idle == 0, "R7", "no lock after reset count", 64'(fetch_idle), 64'(0));
    loop_pass(20, 23, 1);
    chk(fetch_idle == 1, "R7", "lock after two fresh passes", 64'(fetch_idle), 64'(1));
    repeat (20) step();
    do_flush();

    // R4: target never seen, no lock; duplicate target picks the nearest copy
    for (int p = 0; p < 4; p++) begin
      for (int t = 30; t < 34; t++) send(t, 0, 0, 0);
      send(34, 1, 1, 99);
    end
    chk(fetch_idle == 0, "R4", "absent target never locks", 64'(fetch_idle), 64'(0));
    for (int p = 0; p < 2; p++) begin
      send(40, 0, 0, 0); send(41, 0, 0, 0); send(40, 0, 0, 0); send(42, 0, 0, 0);
      send(43, 1, 1, 40);
    end
    chk(fetch_idle == 1, "R4", "duplicate target locks", 64'(fetch_idle), 64'(1));
    for (int i = 0; i < 40; i++) begin out_ready = ($urandom % 2) != 0; step(); end
    out_ready = 1;
    do_flush();

    // R9: body of exactly DEPTH locks, DEPTH+1 does not
    loop_pass(100, 100 + DEPTH - 1, 1);
    loop_pass(100, 100 + DEPTH - 1, 1);
    chk(fetch_idle == 1, "R9", "full-depth body locks", 64'(fetch_idle), 64'(1));
    repeat (70) step();
    do_flush();
    for (int p = 0; p < 3; p++) loop_pass(100, 100 + DEPTH, 1);
    chk(fetch_idle == 0, "R9", "oversize body never locks", 64'(fetch_idle), 64'(0));
    do_flush();

    // R10: a flush between passes discards the first pass
    loop_pass(50, 53, 1);
    do_flush();
    loop_pass(50, 53, 1);
    chk(fetch_idle == 0, "R10", "no lock across flush", 64'(fetch_idle), 64'(0));
    loop_pass(50, 53, 1);
    chk(fetch_idle == 1, "R10", "lock after flush and two passes", 64'(fetch_idle), 64'(1));
    repeat (15) step();
    do_flush();

    // random mix against the model
    for (int i = 0; i < 5000; i++) begin
      in_valid    = ($urandom % 4) != 0;
      in_tag      = TAG_W'($urandom % 16);
      in_is_br    = ($urandom % 5) == 0;
      in_br_taken = ($urandom % 4) != 0;
      in_br_tgt   = TAG_W'($urandom % 16);
      in_uop      = $urandom;
      out_ready   = ($urandom % 4) != 0;
      flush       = ($urandom % 150) == 0;
      loop_exit   = m_rep && (($urandom % 25) == 0);
      step();
    end
    in_valid = 0; flush = 0; loop_exit = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule